// File: doc/BRIEF.md
# Parallel Result and Configuration Port with Word/Byte Transfers

This block is the host-facing side of a multichannel sampling converter. A processor reaches it through an active-low chip select, a read strobe, a write strobe and a 12-bit data bus. The bus is split here into an input vector, an output vector and one output enable, so the pads stay outside the block. On reads it returns the most recent conversion result together with the channel that produced it. Writes become configuration words for the channel sequencer.

A mode input picks the transfer width. When the mode is high, every transfer carries a full 12-bit value. When it is low, the bus narrows to eight lines. Data line 8 then acts as a high-part select input, so one value moves as a low byte and a high part. A byte-mode write keeps the low byte in a holding register and releases the whole configuration word when the high part arrives. A byte-mode read of the high part places the 3-bit channel number next to the top four result bits.

Strobes are taken as already synchronous to `clk`. Each read or write decision is made on a clock edge. The result register changes only when the converter reports completion, so a read made during a conversion sees the previous sample.

Top module: `dport_parallel_port`

## Requirements
- R1: While `rst_n` is low, at every clock edge `db_oe` is cleared to 0, `db_out` to 0, `cfg_wr` to 0 and `cfg_word` to 0.
- R2: `db_oe` is 1 in the cycle after an edge that sampled `cs_n`=0 and `rd_n`=0, and 0 otherwise. Whenever `db_oe` is 0, `db_out` is all zero.
- R3: A read with `word_mode`=1 drives the latched 12-bit result on `db_out[11:0]`.
- R4: A read with `word_mode`=0 and `db_in[8]`=0 drives result bits 7:0 on `db_out[7:0]`, with `db_out[11:8]` = 0.
- R5: A read with `word_mode`=0 and `db_in[8]`=1 drives result bits 11:8 on `db_out[3:0]` and the latched channel on `db_out[6:4]`, with `db_out[7]` and `db_out[11:8]` = 0.
- R6: The result and channel registers load only on an edge where `conv_done`=1. A read sampled on that same edge returns the earlier value, and later reads return the new one.
- R7: In word mode, a rising edge of `wr_n` while `cs_n`=0 makes `cfg_wr` high for exactly one cycle, with `cfg_word` equal to `db_in[11:0]` sampled at that edge.
- R8: In byte mode, a write with `db_in[8]`=0 stores `db_in[7:0]` in the holding register. It raises no `cfg_wr` and leaves `cfg_word` unchanged. A later low write replaces the stored byte.
- R9: In byte mode, a write with `db_in[8]`=1 makes `cfg_wr` high for one cycle, with `cfg_word` = {`db_in[3:0]`, held low byte}.
- R10: A rising edge of `wr_n` while `cs_n`=1 raises no `cfg_wr` and leaves `cfg_word` unchanged.
- R11: `cfg_word` changes only in a cycle where `cfg_wr` is 1, and holds its value between accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; its rising edge accepts a write |
| word_mode | input | 1 | 1 selects 12-bit transfers, 0 selects byte transfers |
| db_in | input | 12 | Data bus as seen by the block; bit 8 is the high-part select in byte mode |
| db_out | output | 12 | Data the block drives onto the bus |
| db_oe | output | 1 | Output enable for the bus drivers |
| conv_done | input | 1 | One-cycle pulse when a conversion completes |
| conv_result | input | 12 | Result of the completed conversion |
| conv_chan | input | 3 | Channel of the completed conversion |
| cfg_wr | output | 1 | One-cycle pulse when a complete configuration word is ready |
| cfg_word | output | 12 | Configuration word for the sequencer |

## Verification
Reads are run in all three transfer shapes against a result whose low byte, high nibble and channel hold different values. A wrong lane, a missing channel field, or a stray bit on a spare line therefore shows up as a distinct value. A read issued on the same edge as a completion pulse tells a result register that loads only on completion apart from one that passes the new sample straight through. Writes cover word mode, a low byte followed by a high part, a repeated low byte, and a strobe with the chip deselected. Together these separate correct assembly from a dropped holding register, a lost overwrite, or a select that is ignored.

// File: rtl/dport_pkg.sv
// Shared types for the parallel data port.
// Assumes: the three transfer shapes are word, low byte and high part.
package dport_pkg;

    typedef enum logic [1:0] {
        XFER_WORD = 2'd0,
        XFER_LOW  = 2'd1,
        XFER_HIGH = 2'd2
    } xfer_kind_t;

    // Choose the transfer shape from the width mode and the high-part select.
    function automatic xfer_kind_t xfer_kind(input logic word_mode, input logic hsel);
        if (word_mode)
            return XFER_WORD;
        else if (hsel)
            return XFER_HIGH;
        else
            return XFER_LOW;
    endfunction

endpackage

// File: rtl/dport_result_latch.sv
// Holds the newest conversion result and its channel number.
// Assumes: conv_done is a one-cycle pulse synchronous to clk.
module dport_result_latch #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic [CHAN_W-1:0] conv_chan,
    output logic [DATA_W-1:0] res_q,
    output logic [CHAN_W-1:0] chan_q
);

    // Load a new sample only when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            chan_q <= '0;
        end else if (conv_done) begin
            res_q  <= conv_result;
            chan_q <= conv_chan;
        end
    end

endmodule

// File: rtl/dport_read_mux.sv
// Builds the read image for the chosen transfer shape and registers it,
// together with the output enable.
// Assumes: HIGH_W + CHAN_W fits within BYTE_W; strobes are synchronous.
module dport_read_mux
    import dport_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  xfer_kind_t        kind,
    input  logic [DATA_W-1:0] res,
    input  logic [CHAN_W-1:0] chan,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe
);

    localparam int HIGH_W = DATA_W - BYTE_W;

    logic              rd_sel;
    logic [DATA_W-1:0] img_low;
    logic [DATA_W-1:0] img_high;
    logic [DATA_W-1:0] img;

    assign rd_sel = !cs_n && !rd_n;

    // Form the low-byte and high-part images, with all spare lines zero.
    always_comb begin
        img_low                   = '0;
        img_low[BYTE_W-1:0]       = res[BYTE_W-1:0];
        img_high                  = '0;
        img_high[HIGH_W-1:0]      = res[DATA_W-1:BYTE_W];
        img_high[HIGH_W +: CHAN_W] = chan;
    end

    // Pick the image that matches the transfer shape.
    always_comb begin
        unique case (kind)
            XFER_WORD: img = res;
            XFER_HIGH: img = img_high;
            default:   img = img_low;
        endcase
    end

    // Register the output and its enable; hold zero while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_oe  <= 1'b0;
            db_out <= '0;
        end else begin
            db_oe  <= rd_sel;
            db_out <= rd_sel ? img : '0;
        end
    end

endmodule

// File: rtl/dport_write_asm.sv
// Accepts writes on the rising edge of the write strobe and assembles
// configuration words, merging byte halves through a holding register.
// Assumes: strobes are synchronous; wr_n idles high.
module dport_write_asm
    import dport_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  xfer_kind_t        kind,
    input  logic [DATA_W-1:0] db_in,
    output logic              cfg_wr,
    output logic [DATA_W-1:0] cfg_word
);

    localparam int HIGH_W = DATA_W - BYTE_W;

    logic              wr_prev;
    logic              wr_take;
    logic [BYTE_W-1:0] hold_lo;

    assign wr_take = !wr_prev && wr_n && !cs_n;

    // Track the previous write strobe level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= wr_n;
    end

    // Keep the low byte of a byte-mode write until its high part arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_lo <= '0;
        else if (wr_take && kind == XFER_LOW)
            hold_lo <= db_in[BYTE_W-1:0];
    end

    // Emit a configuration word on word writes and on high-part writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_wr   <= 1'b0;
            cfg_word <= '0;
        end else begin
            cfg_wr <= 1'b0;
            if (wr_take) begin
                if (kind == XFER_WORD) begin
                    cfg_wr   <= 1'b1;
                    cfg_word <= db_in;
                end else if (kind == XFER_HIGH) begin
                    cfg_wr   <= 1'b1;
                    cfg_word <= {db_in[HIGH_W-1:0], hold_lo};
                end
            end
        end
    end

endmodule

// File: rtl/dport_parallel_port.sv
// Top of the parallel data port: joins the result latch, the read image
// builder and the write assembler; decodes the transfer shape.
// Assumes: all bus inputs are synchronous to clk.
module dport_parallel_port
    import dport_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic [CHAN_W-1:0] conv_chan,
    output logic              cfg_wr,
    output logic [DATA_W-1:0] cfg_word
);

    xfer_kind_t        kind;
    logic [DATA_W-1:0] res_q;
    logic [CHAN_W-1:0] chan_q;

    // Line BYTE_W doubles as the high-part select when bytes are moved.
    assign kind = xfer_kind(word_mode, db_in[BYTE_W]);

    dport_result_latch #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_chan   (conv_chan),
        .res_q       (res_q),
        .chan_q      (chan_q)
    );

    dport_read_mux #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .BYTE_W(BYTE_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .kind   (kind),
        .res    (res_q),
        .chan   (chan_q),
        .db_out (db_out),
        .db_oe  (db_oe)
    );

    dport_write_asm #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .kind     (kind),
        .db_in    (db_in),
        .cfg_wr   (cfg_wr),
        .cfg_word (cfg_word)
    );

endmodule

// File: rtl/dport_checks.sv
// Property checks for the parallel data port, bound to its top module.
// Assumes: default widths keep HIGH_W + CHAN_W within BYTE_W.
module dport_checks #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 3,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              word_mode,
    input logic [DATA_W-1:0] db_in,
    input logic [DATA_W-1:0] db_out,
    input logic              db_oe,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_word
);

    localparam int HIGH_W = DATA_W - BYTE_W;

    // R2: enable follows the sampled read select one cycle later
    a_r2_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (db_oe == $past(!cs_n && !rd_n)));

    // R2: bus image is zero whenever not driven
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !db_oe |-> (db_out == '0));

    // R4, R5: upper lines stay low on byte-mode reads
    a_r5_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && db_oe && !$past(word_mode)) |-> (db_out[DATA_W-1:BYTE_W] == '0));

    // R5: spare line beside the channel field stays low on high-part reads
    a_r5_spare_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && db_oe && !$past(word_mode) && $past(db_in[BYTE_W]))
        |-> (db_out[BYTE_W-1:HIGH_W+CHAN_W] == '0));

    // R7, R9: configuration strobe lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !cfg_wr);

    // R10: a configuration strobe needs a selected rising write edge
    a_r10_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_wr) |-> $past(!cs_n && wr_n));

    // R11: configuration word holds between strobes
    a_r11_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !cfg_wr) |-> $stable(cfg_word));

endmodule

bind dport_parallel_port dport_checks #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .word_mode (word_mode),
    .db_in     (db_in),
    .db_out    (db_out),
    .db_oe     (db_oe),
    .cfg_wr    (cfg_wr),
    .cfg_word  (cfg_word)
);

// File: tb/dport_parallel_port_bench.sv
// Directed bench for the parallel data port: one task per scenario.
module dport_parallel_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        word_mode = 1'b1;
    logic [11:0] db_in = '0;
    logic [11:0] db_out;
    logic        db_oe;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic [2:0]  conv_chan = '0;
    logic        cfg_wr;
    logic [11:0] cfg_word;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dport_parallel_port u_dport_parallel_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .word_mode(word_mode), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
        .conv_done(conv_done), .conv_result(conv_result), .conv_chan(conv_chan),
        .cfg_wr(cfg_wr), .cfg_word(cfg_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_result(input logic [11:0] r, input logic [2:0] c);
        @(negedge clk); conv_done = 1'b1; conv_result = r; conv_chan = c;
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic bus_read(input logic wm, input logic hsel,
                            output logic [11:0] v, output logic oe);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; word_mode = wm; db_in = {3'b0, hsel, 8'h00};
        @(negedge clk); v = db_out; oe = db_oe; cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic bus_write(input logic wm, input logic [11:0] d, input logic csl,
                             output logic pulse, output logic [11:0] w);
        @(negedge clk); cs_n = csl; wr_n = 1'b0; word_mode = wm; db_in = d;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); pulse = cfg_wr; w = cfg_word; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        @(negedge clk);
        chk("R1 oe", {31'b0, db_oe}, 0);
        chk("R1 data", {20'b0, db_out}, 0);
        chk("R1 cfg_wr", {31'b0, cfg_wr}, 0);
        chk("R1 cfg_word", {20'b0, cfg_word}, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_idle_bus();
        logic [11:0] v; logic oe;
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        chk("R2 cs only oe", {31'b0, db_oe}, 0);
        chk("R2 cs only data", {20'b0, db_out}, 0);
        cs_n = 1'b1;
        bus_read(1'b1, 1'b0, v, oe);
        chk("R2 read oe", {31'b0, oe}, 1);
        @(negedge clk);
        chk("R2 released oe", {31'b0, db_oe}, 0);
    endtask

    task automatic t_word_read();
        logic [11:0] v; logic oe;
        load_result(12'hA5C, 3'd6);
        bus_read(1'b1, 1'b0, v, oe);
        chk("R3 word read", {20'b0, v}, 32'hA5C);
        load_result(12'h3E1, 3'd2);
        bus_read(1'b1, 1'b0, v, oe);
        chk("R3 word read 2", {20'b0, v}, 32'h3E1);
    endtask

    task automatic t_byte_read();
        logic [11:0] v; logic oe;
        load_result(12'hB7D, 3'd5);
        bus_read(1'b0, 1'b0, v, oe);
        chk("R4 low byte", {20'b0, v}, 32'h07D);
        bus_read(1'b0, 1'b1, v, oe);
        chk("R5 high part", {20'b0, v}, {20'b0, 4'h0, 1'b0, 3'd5, 4'hB});
        load_result(12'hFFF, 3'd7);
        bus_read(1'b0, 1'b1, v, oe);
        chk("R5 high part all ones", {20'b0, v}, 32'h07F);
    endtask

    task automatic t_read_during_conv();
        logic [11:0] v;
        load_result(12'h123, 3'd1);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; word_mode = 1'b1; db_in = '0;
        conv_done = 1'b1; conv_result = 12'h9AB; conv_chan = 3'd4;
        @(negedge clk); v = db_out; conv_done = 1'b0;
        chk("R6 same edge keeps old", {20'b0, v}, 32'h123);
        @(negedge clk); v = db_out; cs_n = 1'b1; rd_n = 1'b1;
        chk("R6 next read new", {20'b0, v}, 32'h9AB);
        @(negedge clk); conv_result = 12'h555;
        @(negedge clk);
        bus_read_word_check("R6 no load without done", 12'h9AB);
    endtask

    task automatic bus_read_word_check(input string req, input logic [11:0] e);
        logic [11:0] v; logic oe;
        bus_read(1'b1, 1'b0, v, oe);
        chk(req, {20'b0, v}, {20'b0, e});
    endtask

    task automatic t_word_write();
        logic p; logic [11:0] w;
        bus_write(1'b1, 12'hC3A, 1'b0, p, w);
        chk("R7 pulse", {31'b0, p}, 1);
        chk("R7 word", {20'b0, w}, 32'hC3A);
        chk("R7 pulse ends", {31'b0, cfg_wr}, 0);
        chk("R11 word held", {20'b0, cfg_word}, 32'hC3A);
    endtask

    task automatic t_byte_write();
        logic p; logic [11:0] w;
        bus_write(1'b0, 12'h0_11, 1'b0, p, w);
        chk("R8 no pulse", {31'b0, p}, 0);
        chk("R8 word unchanged", {20'b0, w}, 32'hC3A);
        bus_write(1'b0, 12'h0_6E, 1'b0, p, w);
        bus_write(1'b0, 12'h1_F9, 1'b0, p, w);
        chk("R9 pulse", {31'b0, p}, 1);
        chk("R9 assembled", {20'b0, w}, 32'h96E);
    endtask

    task automatic t_ignored_write();
        logic p; logic [11:0] w;
        bus_write(1'b1, 12'h0F0, 1'b1, p, w);
        chk("R10 no pulse", {31'b0, p}, 0);
        chk("R10 word unchanged", {20'b0, w}, 32'h96E);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_idle_bus();
        t_word_read();
        t_byte_read();
        t_read_during_conv();
        t_word_write();
        t_byte_write();
        t_ignored_write();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule